// File: doc/BRIEF.md
# Reconfigurable Set-Associative Cache Controller

This block is a word-access cache controller whose storage is four identical physical ways. Each way is 2 KB and is organised as 128 sets of 16-byte lines. A set of run-time configuration inputs controls three things. The first is how the four ways are grouped: one 4-way cache, a 2-way cache whose way pair is steered by an address bit, or a direct-mapped cache whose single way is chosen by two address bits. The second is which ways are switched off. The third is how many consecutive 16-byte lines a miss fetches: one, two or four.

The two address bits just above the per-way set index pass through a small steering circuit together with the grouping mode and the enable mask. The result is the set of ways an access may probe or allocate into. Every tag keeps all address bits above the set index, so a lookup gives the right answer in every mode. Stores are write-through and never allocate. Any configuration write clears the whole cache before the CPU port accepts work again.

Top module: `cfg_cache`

## Requirements
- R1: After reset, `ready_o` is 1, `rvalid_o` and `mem_req_o` are 0. The block starts in 4-way mode with all ways enabled and single-line (16-byte) fills.
- R2: A read that hits returns its word with `rvalid_o` at the first clock edge after acceptance and makes no memory request. The hit latency is the same in every grouping mode.
- R3: Way steering uses address bits [12:11]. Mode code 2 or 3 allows all four ways. Mode code 1 allows ways 0 and 1 when bit 11 is 0, and ways 2 and 3 when bit 11 is 1. Mode code 0 allows only the way numbered by bits [12:11].
- R4: A way whose bit in `cfg_way_en_i` is 0 never hits and is never allocated. If an address has no allowed way, every read of it misses, fetches from memory and still returns the correct word.
- R5: On an allocating miss, the victim is the first allowed way found cyclically upward from the set's replacement pointer. The pointer then moves to the way after the victim. Pointers are cleared by a configuration write.
- R6: A read miss fetches 1, 2 or 4 physical lines (`cfg_fill_i` = 0, 1, 2 or 3) in ascending order, starting at the address aligned to the logical line size. Each line is one memory request followed by 4 data beats in ascending word order. `rvalid_o` rises at the edge that takes the last beat, carrying the requested word, and every fetched line is then resident.
- R7: Every store produces one memory write of its word-aligned address and data. A store that hits updates the cached word. A store that misses allocates nothing, so a later read of that address misses.
- R8: A configuration write accepted while `ready_o` is 1 invalidates all lines. `ready_o` stays 0 for exactly 128 cycles (one per set), and the new mode applies to the following accesses.
- R9: When `cfg_we_i` and `req_i` are both 1 in the same ready cycle, the configuration write is taken and the CPU request is dropped: it gets no response and causes no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_assoc_i | input | 2 | Grouping mode: 0 direct, 1 two-way, 2/3 four-way |
| cfg_way_en_i | input | 4 | Per-way enable mask |
| cfg_fill_i | input | 2 | Fill length: 0 one line, 1 two lines, 2/3 four lines |
| req_i | input | 1 | CPU request |
| we_i | input | 1 | CPU request is a store |
| addr_i | input | ADDR_W | CPU byte address (bits [1:0] ignored) |
| wdata_i | input | 32 | Store data |
| ready_o | output | 1 | Block accepts a request or configuration write |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a word write |
| mem_addr_o | output | ADDR_W | Memory address (line address for fills) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Fill data beat valid |
| mem_rdata_i | input | 32 | Fill data beat |

## Verification
The bench goes after lines that share a set but differ only in bits [12:11] or above. It exercises them in each grouping mode, so a wrong steering circuit shows up as a missing or extra eviction, and a tag that dropped bits [12:11] would alias two lines into one false hit. Fills of two and four lines are checked for order, alignment and total latency. A sequencer that skipped a line or released the CPU early would miss on a neighbour line or return the wrong word. Stores to resident and absent lines reveal a design that forgets to update the cached copy or allocates on a store. Disabled ways and a configuration write coinciding with a request reveal allocation into a switched-off way, and a request that leaks through the flush.

// File: rtl/cfg_cache_pkg.sv
package cfg_cache_pkg;
  localparam int NUM_WAYS    = 4;
  localparam int WAY_W       = $clog2(NUM_WAYS);
  localparam int WAY_BYTES   = 2048;
  localparam int LINE_BYTES  = 16;
  localparam int WORD_W      = 32;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int OFF_W       = $clog2(LINE_BYTES);
  localparam int BEATS       = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W      = $clog2(BEATS);
  localparam int SETS        = WAY_BYTES / LINE_BYTES;
  localparam int IDX_W       = $clog2(SETS);
  localparam int TAG_LSB     = OFF_W + IDX_W;
  localparam int MAX_FILL_SH = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_STORE,
    ST_FREQ,
    ST_FDATA
  } state_e;
endpackage

// File: rtl/cfg_cache_waysel.sv
module cfg_cache_waysel
  import cfg_cache_pkg::*;
(
  input  logic [1:0]          assoc_i,
  input  logic [1:0]          hi_bits_i,
  input  logic [NUM_WAYS-1:0] way_en_i,
  output logic [NUM_WAYS-1:0] allow_o
);
  logic [NUM_WAYS-1:0] sel;

  always_comb begin
    unique case (assoc_i)
      2'd0:    sel = NUM_WAYS'(1) << hi_bits_i;
      2'd1:    sel = hi_bits_i[0] ? 4'b1100 : 4'b0011;
      default: sel = '1;
    endcase
    allow_o = sel & way_en_i;
  end
endmodule

// File: rtl/cfg_cache_tags.sv
module cfg_cache_tags
  import cfg_cache_pkg::*;
#(
  parameter int TAG_W = 21
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    lk_idx_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  input  logic [NUM_WAYS-1:0] allow_i,
  output logic [NUM_WAYS-1:0] hit_vec_o,
  output logic [WAY_W-1:0]    victim_o,
  input  logic                wr_en_i,
  input  logic [WAY_W-1:0]    wr_way_i,
  input  logic                rr_adv_i,
  input  logic                flush_i,
  input  logic [IDX_W-1:0]    flush_idx_i
);
  logic [TAG_W-1:0]    tag_q [SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] vld_q [SETS];
  logic [WAY_W-1:0]    rr_q  [SETS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = vld_q[lk_idx_i][w] && allow_i[w] &&
                          (tag_q[lk_idx_i][w] == lk_tag_i);
  end

  always_comb begin
    logic             found;
    logic [WAY_W-1:0] cand;
    victim_o = '0;
    found    = 1'b0;
    cand     = '0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      cand = rr_q[lk_idx_i] + WAY_W'(k);
      if (!found && allow_i[cand]) begin
        victim_o = cand;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !flush_i) tag_q[lk_idx_i][wr_way_i] <= lk_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (flush_i) begin
      vld_q[flush_idx_i] <= '0;
      rr_q[flush_idx_i]  <= '0;
    end else if (wr_en_i) begin
      vld_q[lk_idx_i][wr_way_i] <= 1'b1;
      if (rr_adv_i) rr_q[lk_idx_i] <= wr_way_i + WAY_W'(1);
    end
  end

  // R3: steering leaves at most one resident copy of a line visible
  p_hit_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o));

  // R4: allocation only into an allowed, enabled way
  p_wr_allowed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> allow_i[wr_way_i]);
endmodule

// File: rtl/cfg_cache_data.sv
module cfg_cache_data
  import cfg_cache_pkg::*;
(
  input  logic              clk_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WSEL_W-1:0] rd_word_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WSEL_W-1:0] wr_word_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  localparam int DEPTH = NUM_WAYS * SETS * BEATS;
  localparam int AW    = $clog2(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[AW'({rd_way_i, rd_idx_i, rd_word_i})];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[AW'({wr_way_i, wr_idx_i, wr_word_i})] <= wr_data_i;
  end
endmodule

// File: rtl/cfg_cache.sv
module cfg_cache
  import cfg_cache_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_assoc_i,
  input  logic [NUM_WAYS-1:0] cfg_way_en_i,
  input  logic [1:0]          cfg_fill_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic                ready_o,
  output logic                rvalid_o,
  output logic [WORD_W-1:0]   rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic                mem_gnt_i,
  input  logic                mem_rvalid_i,
  input  logic [WORD_W-1:0]   mem_rdata_i
);
  localparam int TAG_W = ADDR_W - TAG_LSB;
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(BEATS - 1);

  state_e              state_q;
  logic [1:0]          assoc_q, fill_q;
  logic [NUM_WAYS-1:0] en_q;
  logic [IDX_W-1:0]    flush_cnt_q;
  logic [ADDR_W-1:0]   line_base_q;
  logic [1:0]          line_k_q, lines_last_q;
  logic [WSEL_W-1:0]   beat_q;
  logic [LN_W-1:0]     req_line_q;
  logic [WSEL_W-1:0]   req_word_q;
  logic [WAY_W-1:0]    fill_way_q;
  logic                fill_alloc_q, fill_new_q;
  logic [ADDR_W-3:0]   st_addr_q;
  logic [WORD_W-1:0]   st_data_q;
  logic                rvalid_q;
  logic [WORD_W-1:0]   rdata_q;

  logic [ADDR_W-1:0]   fill_addr, lk_addr, base_mask;
  logic [IDX_W-1:0]    lk_idx;
  logic [TAG_W-1:0]    lk_tag;
  logic [NUM_WAYS-1:0] allow, hit_vec;
  logic [WAY_W-1:0]    hit_way, victim;
  logic                hit, acc;
  logic [WORD_W-1:0]   d_rd;
  logic                d_we, t_we;
  logic [1:0]          fill_sh;

  assign fill_addr = line_base_q | (ADDR_W'(line_k_q) << OFF_W);
  assign lk_addr   = (state_q == ST_IDLE) ? addr_i : fill_addr;
  assign lk_idx    = lk_addr[TAG_LSB-1:OFF_W];
  assign lk_tag    = lk_addr[ADDR_W-1:TAG_LSB];
  assign hit       = |hit_vec;
  assign ready_o   = (state_q == ST_IDLE);
  assign acc       = ready_o && req_i && !cfg_we_i;

  logic unused_ok;
  assign unused_ok = ^{lk_addr[OFF_W-1:0], addr_i[1:0]};

  cfg_cache_waysel u_waysel (
    .assoc_i   (assoc_q),
    .hi_bits_i (lk_addr[TAG_LSB+1:TAG_LSB]),
    .way_en_i  (en_q),
    .allow_o   (allow)
  );

  cfg_cache_tags #(.TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_idx_i    (lk_idx),
    .lk_tag_i    (lk_tag),
    .allow_i     (allow),
    .hit_vec_o   (hit_vec),
    .victim_o    (victim),
    .wr_en_i     (t_we),
    .wr_way_i    (fill_way_q),
    .rr_adv_i    (fill_new_q),
    .flush_i     (state_q == ST_FLUSH),
    .flush_idx_i (flush_cnt_q)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign d_we = (acc && we_i && hit) ||
                (state_q == ST_FDATA && mem_rvalid_i && fill_alloc_q);
  assign t_we = state_q == ST_FDATA && mem_rvalid_i && fill_alloc_q &&
                beat_q == LAST_BEAT;

  cfg_cache_data u_data (
    .clk_i     (clk_i),
    .rd_way_i  (hit_way),
    .rd_idx_i  (lk_idx),
    .rd_word_i (addr_i[OFF_W-1:2]),
    .rd_data_o (d_rd),
    .we_i      (d_we),
    .wr_way_i  (ready_o ? hit_way : fill_way_q),
    .wr_idx_i  (lk_idx),
    .wr_word_i (ready_o ? addr_i[OFF_W-1:2] : beat_q),
    .wr_data_i (ready_o ? wdata_i : mem_rdata_i)
  );

  // fill length code -> shift of the logical line size
  always_comb begin
    fill_sh   = (fill_q > 2'(MAX_FILL_SH)) ? 2'(MAX_FILL_SH) : fill_q;
    base_mask = ~((ADDR_W'(LINE_BYTES) << fill_sh) - ADDR_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      assoc_q      <= 2'd2;
      en_q         <= '1;
      fill_q       <= 2'd0;
      flush_cnt_q  <= '0;
      line_base_q  <= '0;
      line_k_q     <= '0;
      lines_last_q <= '0;
      beat_q       <= '0;
      req_line_q   <= '0;
      req_word_q   <= '0;
      fill_way_q   <= '0;
      fill_alloc_q <= 1'b0;
      fill_new_q   <= 1'b0;
      st_addr_q    <= '0;
      st_data_q    <= '0;
      rvalid_q     <= 1'b0;
      rdata_q      <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cfg_we_i) begin
            assoc_q     <= cfg_assoc_i;
            en_q        <= cfg_way_en_i;
            fill_q      <= cfg_fill_i;
            flush_cnt_q <= '0;
            state_q     <= ST_FLUSH;
          end else if (req_i) begin
            if (we_i) begin
              st_addr_q <= addr_i[ADDR_W-1:2];
              st_data_q <= wdata_i;
              state_q   <= ST_STORE;
            end else if (hit) begin
              rvalid_q <= 1'b1;
              rdata_q  <= d_rd;
            end else begin
              line_base_q  <= addr_i & base_mask;
              line_k_q     <= '0;
              lines_last_q <= 2'((1 << fill_sh) - 1);
              req_line_q   <= addr_i[ADDR_W-1:OFF_W];
              req_word_q   <= addr_i[OFF_W-1:2];
              state_q      <= ST_FREQ;
            end
          end
        end
        ST_FLUSH: begin
          flush_cnt_q <= flush_cnt_q + IDX_W'(1);
          if (flush_cnt_q == LAST_SET) state_q <= ST_IDLE;
        end
        ST_STORE: if (mem_gnt_i) state_q <= ST_IDLE;
        ST_FREQ: begin
          if (mem_gnt_i) begin
            beat_q  <= '0;
            state_q <= ST_FDATA;
            if (hit) begin
              fill_way_q   <= hit_way;
              fill_alloc_q <= 1'b1;
              fill_new_q   <= 1'b0;
            end else begin
              fill_way_q   <= victim;
              fill_alloc_q <= |allow;
              fill_new_q   <= |allow;
            end
          end
        end
        ST_FDATA: begin
          if (mem_rvalid_i) begin
            if (fill_addr[ADDR_W-1:OFF_W] == req_line_q && beat_q == req_word_q)
              rdata_q <= mem_rdata_i;
            beat_q <= beat_q + WSEL_W'(1);
            if (beat_q == LAST_BEAT) begin
              if (line_k_q == lines_last_q) begin
                rvalid_q <= 1'b1;
                state_q  <= ST_IDLE;
              end else begin
                line_k_q <= line_k_q + 2'd1;
                state_q  <= ST_FREQ;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (state_q == ST_STORE) || (state_q == ST_FREQ);
  assign mem_we_o    = (state_q == ST_STORE);
  assign mem_addr_o  = (state_q == ST_STORE) ? {st_addr_q, 2'b00} : fill_addr;
  assign mem_wdata_o = st_data_q;

  // R2: a hit answers next edge without memory traffic
  p_hit_no_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !we_i && hit) |=> (rvalid_o && !mem_req_o));

  // R6: fill requests are line aligned
  p_fill_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o[OFF_W-1:0] == '0));

  // R7: each accepted store goes out to memory
  p_store_fwd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && we_i) |=> (mem_req_o && mem_we_o));

  // R8: a configuration write stalls the port
  p_cfg_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cfg_we_i) |=> !ready_o);

  // R9: a request colliding with a configuration write is dropped
  p_cfg_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cfg_we_i && req_i) |=> (!mem_req_o && !rvalid_o));
endmodule

// File: tb/cfg_cache_tb_top.sv
module cfg_cache_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_assoc_i = '0;
  logic [3:0]  cfg_way_en_i = '0;
  logic [1:0]  cfg_fill_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ready_o, rvalid_o, mem_req_o, mem_we_o;
  logic [31:0] rdata_o, mem_addr_o, mem_wdata_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfg_cache dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_assoc_i(cfg_assoc_i),
    .cfg_way_en_i(cfg_way_en_i), .cfg_fill_i(cfg_fill_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .rvalid_o(rvalid_o),
    .rdata_o(rdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory image ----------------
  bit [31:0] written [int unsigned];

  function automatic bit [31:0] mem_val(input int unsigned a);
    int unsigned wa = a & ~32'h3;
    if (written.exists(wa)) return written[wa];
    return {wa[15:0] ^ 16'h3C5A, ~wa[15:0]};
  endfunction

  // expected memory operations, in order
  int unsigned exp_addr[$];
  bit          exp_we[$];
  bit [31:0]   exp_data[$];
  string       cur_req = "R6";

  // memory responder: grant one request, then 4 beats for reads
  initial begin
    int unsigned line_cap;
    bit          we_cap;
    int          beats;
    bit          granted;
    line_cap = 0; we_cap = 0; beats = 0;
    forever begin
      @(negedge clk_i);
      mem_rvalid_i = 1'b0;
      granted = 1'b0;
      if (!rst_ni) begin
        mem_gnt_i = 1'b0;
        beats = 0;
      end else begin
        if (mem_gnt_i) begin
          mem_gnt_i = 1'b0;
          granted = 1'b1;
          if (!we_cap) beats = 4;
        end
        if (beats > 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem_val(line_cap + 32'(4 * (4 - beats)));
          beats--;
        end else if (!granted && mem_req_o) begin
          mem_gnt_i = 1'b1;
          line_cap  = mem_addr_o;
          we_cap    = mem_we_o;
          if (exp_addr.size() == 0) begin
            chk(1'b0, cur_req, "unexpected memory request", mem_addr_o, 0);
          end else begin
            chk(exp_addr[0] == mem_addr_o && exp_we[0] == mem_we_o &&
                (!mem_we_o || exp_data[0] == mem_wdata_o),
                cur_req, "memory request address", mem_addr_o, exp_addr[0]);
            void'(exp_addr.pop_front());
            void'(exp_we.pop_front());
            void'(exp_data.pop_front());
          end
        end
      end
    end
  end

  // ---------------- reference cache model ----------------
  bit          m_vld[128][4];
  int unsigned m_tag[128][4];
  int          m_rr[128];
  int          m_assoc = 2;
  int          m_en = 'hF;
  int          m_fill = 0;

  function automatic int allow_of(input int unsigned a);
    int hi = int'((a >> 11) & 3);
    int sel;
    if (m_assoc == 0) sel = 1 << hi;
    else if (m_assoc == 1) sel = (hi & 1) ? 'hC : 'h3;
    else sel = 'hF;
    return sel & m_en;
  endfunction

  function automatic int find_hit(input int unsigned a);
    int s = int'((a >> 4) & 127);
    int al = allow_of(a);
    for (int w = 0; w < 4; w++)
      if (al[w] && m_vld[s][w] && m_tag[s][w] == (a >> 11)) return w;
    return -1;
  endfunction

  task automatic model_read(input int unsigned a, output int lat);
    int n;
    int unsigned base;
    if (find_hit(a) >= 0) begin
      lat = 0;
      return;
    end
    n = 1 << ((m_fill > 2) ? 2 : m_fill);
    base = a & ~(32'(16 * n) - 1);
    for (int k = 0; k < n; k++) begin
      int unsigned la = base + 32'(16 * k);
      int s = int'((la >> 4) & 127);
      int al = allow_of(la);
      int w;
      exp_addr.push_back(la); exp_we.push_back(1'b0); exp_data.push_back('0);
      if (al != 0) begin
        w = find_hit(la);
        if (w < 0) begin
          for (int j = 0; j < 4; j++) begin
            int c = (m_rr[s] + j) % 4;
            if (w < 0 && al[c]) w = c;
          end
          m_rr[s] = (w + 1) % 4;
        end
        m_vld[s][w] = 1'b1;
        m_tag[s][w] = la >> 11;
      end
    end
    lat = 5 * n;
  endtask

  // ---------------- operations ----------------
  task automatic rd(input int unsigned a, input string req);
    int exp_lat;
    int lat;
    cur_req = req;
    model_read(a, exp_lat);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    lat = 0;
    while (!rvalid_o && lat < 100) begin
      lat++;
      @(negedge clk_i);
    end
    chk(lat == exp_lat, req, $sformatf("read latency @%08h", a), lat, exp_lat);
    chk(rdata_o == mem_val(a), req, $sformatf("read data @%08h", a), rdata_o, mem_val(a));
    chk(exp_addr.size() == 0, req, "pending memory requests", exp_addr.size(), 0);
    while (!ready_o) @(negedge clk_i);
  endtask

  task automatic wr(input int unsigned a, input bit [31:0] d, input string req);
    int guard;
    cur_req = req;
    written[a & ~32'h3] = d;
    exp_addr.push_back(a & ~32'h3); exp_we.push_back(1'b1); exp_data.push_back(d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    guard = 0;
    while (!ready_o && guard < 100) begin
      guard++;
      @(negedge clk_i);
    end
    chk(exp_addr.size() == 0, req, "store not forwarded", exp_addr.size(), 0);
  endtask

  task automatic cfg(input int assoc, input int en, input int fill, input bit with_req,
                     input string req);
    int stall;
    bit quiet;
    cur_req = req;
    cfg_we_i = 1'b1; cfg_assoc_i = 2'(assoc); cfg_way_en_i = 4'(en); cfg_fill_i = 2'(fill);
    if (with_req) begin
      req_i = 1'b1; we_i = 1'b0; addr_i = 32'h0000_0040;
    end
    @(negedge clk_i);
    cfg_we_i = 1'b0; req_i = 1'b0;
    m_assoc = assoc; m_en = en; m_fill = fill;
    for (int s = 0; s < 128; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
    end
    stall = 0;
    quiet = 1'b1;
    while (!ready_o && stall < 1000) begin
      if (rvalid_o || mem_req_o) quiet = 1'b0;
      stall++;
      @(negedge clk_i);
    end
    chk(stall == 128, "R8", "flush stall cycles", stall, 128);
    chk(quiet, req, "activity during flush", 0, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    for (int s = 0; s < 128; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R1", "ready after reset", ready_o, 1);
    chk(rvalid_o == 1'b0, "R1", "rvalid after reset", rvalid_o, 0);
    chk(mem_req_o == 1'b0, "R1", "mem_req after reset", mem_req_o, 0);

    // R1/R2: default 4-way, single-line fill
    rd(32'h0000_1044, "R1");
    rd(32'h0000_1044, "R2");
    rd(32'h0000_1048, "R2");
    rd(32'h0000_1054, "R6");

    // R5: five lines in one set, 4-way round robin
    for (int k = 0; k < 5; k++) rd(32'h0000_0040 + 32'(k * 32'h800), "R5");
    rd(32'h0000_0040, "R5");
    rd(32'h0000_0840, "R5");

    // R7: store hit updates, store miss does not allocate
    wr(32'h0000_1044, 32'hDEAD_BEEF, "R7");
    rd(32'h0000_1044, "R7");
    wr(32'h0000_3300, 32'h1234_5678, "R7");
    rd(32'h0000_3300, "R7");

    // R8/R6: four-line fill
    cfg(2, 'hF, 2, 1'b0, "R8");
    rd(32'h0000_1044, "R8");
    rd(32'h0000_2034, "R6");
    rd(32'h0000_2000, "R6");
    rd(32'h0000_2010, "R6");
    rd(32'h0000_203C, "R6");

    // R3: 2-way, two-line fill; pairs steered by bit 11
    cfg(1, 'hF, 1, 1'b0, "R3");
    rd(32'h0000_0104, "R3");
    rd(32'h0000_1100, "R3");
    rd(32'h0000_0900, "R3");
    rd(32'h0000_4100, "R3");
    rd(32'h0000_0100, "R3");
    rd(32'h0000_0900, "R3");
    rd(32'h0000_0110, "R2");

    // R3: direct mapped
    cfg(0, 'hF, 0, 1'b0, "R3");
    rd(32'h0000_0200, "R3");
    rd(32'h0000_0A00, "R3");
    rd(32'h0000_2200, "R3");
    rd(32'h0000_0200, "R3");
    rd(32'h0000_0A00, "R2");

    // R4: ways 2,3 disabled in 4-way
    cfg(2, 'h3, 0, 1'b0, "R4");
    rd(32'h0000_0300, "R4");
    rd(32'h0000_0B00, "R4");
    rd(32'h0000_1300, "R4");
    rd(32'h0000_0300, "R4");
    rd(32'h0000_1300, "R4");

    // R4: direct mapped with way 0 off
    cfg(0, 'hE, 0, 1'b0, "R4");
    rd(32'h0000_0400, "R4");
    rd(32'h0000_0400, "R4");
    rd(32'h0000_0C00, "R4");
    rd(32'h0000_0C00, "R4");

    // R9: configuration write collides with a read request
    cfg(2, 'hF, 0, 1'b1, "R9");
    rd(32'h0000_0C00, "R9");

    @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule